// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Register

This block is the serial test port of a memory device. It is clocked by the test clock and steered by the mode-select line. It holds the sixteen-state test-port controller, a three-bit instruction register, a one-bit bypass register, a 32-bit identification register and a boundary chain of parallel-capture cells. Each boundary cell has its own update latch behind it. All data moves in on `tdi` and out on `tdo`. The bit nearest `tdo` always leaves first.

Four instructions are decoded:
- The identification read puts the fixed 32-bit word on the serial path.
- Sample/preload snapshots the pad states and preloads the update latches while the pads stay under normal control.
- External test hands the pads to the update latches.
- Bypass shortens the path to one cell.

Any other code behaves as bypass. The serial output is launched on the falling test-clock edge. It is enabled only while a shift state is active; `tdo_oe` stands in for the tri-state pad control.

Top module: `scan_port`

## Requirements
- R1: State changes follow the sixteen-state test-port diagram, with `tms` sampled on the rising edge of `tck`. This includes holding in Shift-DR while `tms` is 0, and leaving a shift through Exit1 and Pause into Exit2, then resuming the shift without losing the shifted bits.
- R2: From any state, five rising edges with `tms` at 1 reach Test-Logic-Reset. A low `rst_n` at a rising edge does the same.
- R3: While the controller is in Test-Logic-Reset, the active instruction becomes the identification read (code 001). A data scan straight after reset therefore shifts out the identification word.
- R4: The identification word is laid out as follows, and it shifts out bit 0 first:
  - bit 0 is 1;
  - bits 11:1 hold the vendor code 00000110100;
  - bits 28:12 hold the 17-bit device code;
  - bits 31:29 hold the revision 000.
- R5: In Capture-IR the instruction shift stage loads 001. The first three `tdo` bits of an instruction scan are therefore 1, 0, 0.
- R6: Instruction codes are 000 external test, 001 identification read, 010 sample/preload and 111 bypass. Bypass and every other code (011, 100, 101, 110) select the one-bit bypass cell. That cell captures 0, so the first `tdo` bit is 0 and each later bit repeats the `tdi` bit of the cycle before.
- R7: Under sample/preload, Capture-DR loads `pad_in` into the chain, with cell 0 nearest `tdo`. Update-DR copies the shifted pattern into `pad_out`, and `pad_drive` stays 0.
- R8: Under external test, `pad_drive` is 1 and `pad_out` shows the update latches. Capture and update behave as in R7.
- R9: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is 1 only while in Shift-IR or Shift-DR, and `tdo` is 0 while disabled.
- R10: The update latches change only in Update-DR while a boundary instruction is active. The active instruction changes only in Update-IR or Test-Logic-Reset.
- R11: `rst_n` is active low and synchronous to `tck`. It clears the update latches and `tdo`/`tdo_oe`, so `pad_out` is 0 and `pad_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pad_in | input | BSC_LEN | Pad states seen by the boundary cells |
| pad_out | output | BSC_LEN | Boundary update latches |
| pad_drive | output | 1 | High when the latches drive the pads (external test) |

## Verification
A value shifted in at a rising edge appears on `tdo` at the next falling edge, half a cycle later. The bench therefore changes `tms`/`tdi` after each falling edge and reads `tdo` 1 ns after the following falling edge. It captures each bit before the rising edge that would shift it away. For R9 it also reads `tdo` just after a rising edge, to show that the value has not yet moved. Update latches and the active instruction settle at the rising edge that leaves Update-DR/Update-IR. They are checked once the controller is back in Run-Test/Idle, one cycle later.

// File: rtl/scan_pkg.sv
// Shared definitions for the test port: controller states and instruction
// codes. Assumes a 3-bit instruction register.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDREAD = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

endpackage

// File: rtl/tap_state_ctl.sv
// Sixteen-state test-port controller. Samples tms on rising tck.
// Assumes rst_n is synchronous to tck; reset enters Test-Logic-Reset.
module tap_state_ctl
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state selection from the current state and tms
    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
            default:   nxt = ST_TLR;
        endcase
    end

    // State register
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end

endmodule

// File: rtl/tap_instr.sv
// Instruction register: a serial shift stage plus the active-instruction
// latch. Assumes it is driven by decoded controller states.
module tap_instr
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            in_tlr,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_q
);

    // Shift stage: capture the fixed pattern, then shift toward tdo
    always_ff @(posedge tck) begin
        if (!rst_n)       ir_shift <= '0;
        else if (capture) ir_shift <= IR_CAPTURE_PAT;
        else if (shift)   ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Active instruction: forced to identification read in reset state
    always_ff @(posedge tck) begin
        if (!rst_n)      ir_q <= OP_IDREAD;
        else if (in_tlr) ir_q <= OP_IDREAD;
        else if (update) ir_q <= ir_shift;
    end

endmodule

// File: rtl/tap_datareg.sv
// Generic capture/shift data register; bit 0 is nearest tdo.
// Assumes capture and shift are never both asserted.
module tap_datareg #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] q,
    output logic         so
);

    generate
        if (W == 1) begin : g_one
            // Single cell: capture or take tdi directly
            always_ff @(posedge tck) begin
                if (!rst_n)       q <= '0;
                else if (capture) q <= cap_val;
                else if (shift)   q <= tdi;
            end
        end else begin : g_multi
            // Multi-cell: capture in parallel, shift one place toward bit 0
            always_ff @(posedge tck) begin
                if (!rst_n)       q <= '0;
                else if (capture) q <= cap_val;
                else if (shift)   q <= {tdi, q[W-1:1]};
            end
        end
    endgenerate

    assign so = q[0];

endmodule

// File: rtl/scan_port.sv
// Top of the test port: controller, instruction register, bypass,
// identification and boundary registers, update latches and the
// falling-edge tdo launch. Assumes a single test clock domain.
module scan_port
    import scan_pkg::*;
#(
    parameter int          BSC_LEN = 109,
    parameter logic [2:0]  ID_REV  = 3'b000,
    parameter logic [16:0] ID_DEV  = 17'h0B2C5,
    parameter logic [10:0] ID_VEN  = 11'b00000110100
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSC_LEN-1:0] pad_in,
    output logic [BSC_LEN-1:0] pad_out,
    output logic               pad_drive
);

    localparam int          ID_W    = 32;
    localparam logic [31:0] ID_WORD = {ID_REV, ID_DEV, ID_VEN, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] ir_shift, ir_q;
    logic            sel_bsr, sel_id, sel_byp;
    logic            cap_dr, sh_dr;
    logic            so_byp, so_id, so_bsr, so_dr;
    logic [0:0]      byp_q;
    logic [ID_W-1:0] id_q;
    logic [BSC_LEN-1:0] bsr_q;

    tap_state_ctl u_ctl (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
    );

    tap_instr u_ir (
        .tck(tck), .rst_n(rst_n),
        .in_tlr(state == ST_TLR),
        .capture(state == ST_CAP_IR),
        .shift(state == ST_SH_IR),
        .update(state == ST_UPD_IR),
        .tdi(tdi), .ir_shift(ir_shift), .ir_q(ir_q)
    );

    // Register selection from the active instruction
    always_comb begin
        sel_bsr = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);
        sel_id  = (ir_q == OP_IDREAD);
        sel_byp = !sel_bsr && !sel_id;
    end

    assign cap_dr = (state == ST_CAP_DR);
    assign sh_dr  = (state == ST_SH_DR);

    tap_datareg #(.W(1)) u_byp (
        .tck(tck), .rst_n(rst_n),
        .capture(cap_dr && sel_byp), .shift(sh_dr && sel_byp),
        .tdi(tdi), .cap_val(1'b0), .q(byp_q), .so(so_byp)
    );

    tap_datareg #(.W(ID_W)) u_id (
        .tck(tck), .rst_n(rst_n),
        .capture(cap_dr && sel_id), .shift(sh_dr && sel_id),
        .tdi(tdi), .cap_val(ID_WORD), .q(id_q), .so(so_id)
    );

    tap_datareg #(.W(BSC_LEN)) u_bsr (
        .tck(tck), .rst_n(rst_n),
        .capture(cap_dr && sel_bsr), .shift(sh_dr && sel_bsr),
        .tdi(tdi), .cap_val(pad_in), .q(bsr_q), .so(so_bsr)
    );

    // Serial output of the selected data register
    always_comb begin
        if (sel_bsr)     so_dr = so_bsr;
        else if (sel_id) so_dr = so_id;
        else             so_dr = so_byp;
    end

    // Boundary update latches, loaded in Update-DR
    always_ff @(posedge tck) begin
        if (!rst_n)                             pad_out <= '0;
        else if (state == ST_UPD_DR && sel_bsr) pad_out <= bsr_q;
    end

    // Pads follow the latches only under external test
    assign pad_drive = (ir_q == OP_EXTEST);

    // tdo launch on the falling edge, enabled in shift states only
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == ST_SH_IR) begin
            tdo    <= ir_shift[0];
            tdo_oe <= 1'b1;
        end else if (state == ST_SH_DR) begin
            tdo    <= so_dr;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
// Property checker for scan_port, attached by bind. Observes the
// controller state, instruction register and outputs.
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int BSC_LEN = 109
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tms,
    input tap_state_e         state,
    input logic [IR_W-1:0]    ir_q,
    input logic [IR_W-1:0]    ir_shift,
    input logic               tdo_oe,
    input logic [BSC_LEN-1:0] pad_out
);

    logic [2:0] hi_cnt;

    // Count consecutive rising edges with tms high, saturating at five
    always_ff @(posedge tck) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!tms)           hi_cnt <= '0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_cnt == 3'd5) |-> (state == ST_TLR));

    // R1
    shift_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_SH_DR && !tms) |=> (state == ST_SH_DR));

    // R3
    reset_ir_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_TLR) |=> (ir_q == OP_IDREAD));

    // R5
    capture_ir_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_shift == 3'b001));

    // R9
    oe_window_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R10
    latch_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_DR) |=> $stable(pad_out));

    // R10
    ir_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

endmodule

bind scan_port scan_port_chk #(.BSC_LEN(BSC_LEN)) u_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state),
    .ir_q(ir_q), .ir_shift(ir_shift), .tdo_oe(tdo_oe), .pad_out(pad_out)
);

// File: tb/tb_scan_port.sv
// Self-checking bench for scan_port. Inputs change after falling edges;
// tdo is read 1 ns after a falling edge.
module tb_scan_port;

    localparam int          N   = 109;
    localparam logic [16:0] DEV = 17'h0B2C5;
    localparam logic [10:0] VEN = 11'b00000110100;
    localparam logic [31:0] EXP_ID = {3'b000, DEV, VEN, 1'b1};

    logic         tck = 0, rst_n = 0, tms = 1, tdi = 0;
    logic         tdo, tdo_oe, pad_drive;
    logic [N-1:0] pad_in = '0, pad_out;

    int n_chk = 0, n_fail = 0, cyc = 0;

    scan_port #(.BSC_LEN(N), .ID_REV(3'b000), .ID_DEV(DEV), .ID_VEN(VEN)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_drive(pad_drive)
    );

    always #2 tck = ~tck;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge tck) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected < 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic d);
        tms = t; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic ir_scan(input logic [2:0] code, output logic [2:0] got);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            got[i] = tdo;
            step(i == 2, code[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic dr_scan(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    logic [2:0]   g3;
    logic [127:0] got, pat_a, pat_b, pin_a, pin_b;

    initial begin
        pin_a = {32'h1F2E3D4C, 32'hA5C30F96, 32'h5A5AC3C3, 32'h0123ABCD};
        pin_b = ~pin_a ^ {4{32'h00FF00FF}};
        pat_a = {32'hDEADBEEF, 32'h13579BDF, 32'h2468ACE0, 32'h76543210};
        pat_b = pat_a ^ {4{32'hF0F0F0F0}};

        repeat (4) @(posedge tck);
        @(negedge tck); rst_n = 1; #1;
        // R11: reset state
        check(pad_out == '0, "R11 pad_out", pad_out, 0);
        check(!pad_drive && !tdo_oe && !tdo, "R11 drive/oe/tdo", {pad_drive, tdo_oe, tdo}, 0);

        step(0, 0);
        // R3 R4: identification word right after reset
        dr_scan(32, '0, got);
        check(got[31:0] == EXP_ID, "R3/R4 id word", got, EXP_ID);
        check(!tdo_oe, "R9 oe in idle", tdo_oe, 0);

        // R5: captured instruction pattern
        ir_scan(OP_BYP(), g3);
        check(g3 == 3'b001, "R5 capture-IR", g3, 3'b001);

        // R6: bypass and undecoded codes give a one-cell path
        for (int c = 3; c < 8; c++) begin
            ir_scan(c[2:0], g3);
            dr_scan(6, 128'b101101, got);
            check(got[5:0] == 6'b011010, $sformatf("R6 bypass code %0d", c), got[5:0], 6'b011010);
        end

        // R9: tdo launch on falling edge (bypass selected, in Shift-DR)
        step(1, 0); step(0, 0); step(0, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        check(tdo == 1'b0, "R9 tdo before fall", tdo, 0);
        @(negedge tck); #1;
        check(tdo == 1'b1 && tdo_oe, "R9 tdo after fall", {tdo_oe, tdo}, 2'b11);

        // R2: five tms-high edges from Shift-DR return to reset, IR back to id read
        for (int k = 0; k < 5; k++) step(1, 0);
        check(!tdo_oe, "R2 oe off in reset", tdo_oe, 0);
        step(0, 0);
        dr_scan(32, '0, got);
        check(got[31:0] == EXP_ID, "R2 id after tms reset", got, EXP_ID);

        // R1: pause in the middle of an id shift
        step(1, 0); step(0, 0); step(0, 0);
        got = '0;
        for (int i = 0; i < 16; i++) begin got[i] = tdo; step(i == 15, 0); end
        step(0, 0); step(0, 0);
        check(!tdo_oe, "R1 oe in pause", tdo_oe, 0);
        step(1, 0); step(0, 0);
        for (int i = 16; i < 32; i++) begin got[i] = tdo; step(i == 31, 0); end
        step(1, 0); step(0, 0);
        check(got[31:0] == EXP_ID, "R1 pause resume", got, EXP_ID);

        // R7: sample/preload
        pad_in = pin_a[N-1:0];
        ir_scan(3'b010, g3);
        check(!pad_drive, "R7 no drive", pad_drive, 0);
        dr_scan(N, pat_a, got);
        check(got[N-1:0] == pin_a[N-1:0], "R7 sampled pads", got, pin_a);
        check(pad_out == pat_a[N-1:0], "R7 preload latches", pad_out, pat_a);

        // R8 R10: external test; instruction change leaves latches untouched
        pad_in = pin_b[N-1:0];
        ir_scan(3'b000, g3);
        check(pad_drive, "R8 drive on", pad_drive, 1);
        check(pad_out == pat_a[N-1:0], "R10 latch kept over IR", pad_out, pat_a);
        dr_scan(N, pat_b, got);
        check(got[N-1:0] == pin_b[N-1:0], "R8 captured pads", got, pin_b);
        check(pad_out == pat_b[N-1:0], "R8 updated latches", pad_out, pat_b);

        // R10: data scan under bypass does not touch the latches
        ir_scan(3'b111, g3);
        dr_scan(8, 128'hA5, got);
        check(pad_out == pat_b[N-1:0], "R10 latch kept over bypass", pad_out, pat_b);
        check(!pad_drive, "R6 bypass releases pads", pad_drive, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic logic [2:0] OP_BYP();
        return 3'b111;
    endfunction

endmodule